// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

A memory-mapped real-time clock core. A 32-bit seconds counter advances by one on every cycle that the one-pulse-per-second strobe `tick_i` is high. Software can overwrite the counter through a load register and read its live value at any time. A match register holds an alarm time. When the counter arrives at that value, a sticky raw alarm flag is set. A one-bit mask gates the flag onto the interrupt line. Writing to the clear register drops the flag.

The block sits in a 4 KB window on a plain 32-bit register bus. Writes take effect on the clock edge at which `sel_i` and `we_i` are both high. Reads are combinational from the word address. Eight identification bytes, one per word, fill the top eight words of the window. The strobe source, calendar logic and any bus bridge lie outside the block.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset, the counter, match, load, mask and raw flag all read 0, and `irq_o` is low.
- R2: Each cycle with `tick_i` high adds one to the counter (byte offset 0x00). The counter wraps from 0xFFFFFFFF to 0. With no tick, the counter holds its value.
- R3: A write to offset 0x08 loads the written value into the counter, and counting continues from there. Reading 0x08 returns the last value written to it. A load wins over a tick in the same cycle.
- R4: Offset 0x04 holds the match value and reads it back. Raw flag bit 0 at offset 0x14 is set on the edge at which the counter becomes equal to the match value through a tick, a load write or a match write. This includes the step across the wrap.
- R5: The raw flag stays set until any write to offset 0x1C, whatever the data. If a setting event happens in the same cycle as a clear write, the flag ends up set.
- R6: Offset 0x10 stores only bit 0 of the written data and reads back as that bit. `irq_o`, and bit 0 of offset 0x18, equal the raw flag AND the mask bit.
- R7: Offset 0x0C always reads 1, and writes to it have no effect.
- R8: Byte offsets 0xFE0, 0xFE4 through 0xFFC read 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended.
- R9: Writes to offsets 0x00, 0x14 and 0x18 change nothing. Reads of 0x1C and of unmapped offsets return 0.
- R10: While the counter sits at the match value and no tick, load or match write happens, a cleared raw flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe, once per second |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable, qualified by `sel_i` |
| addr_i | input | 10 | Word address (byte address bits 11:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Alarm interrupt, high while raw flag AND mask |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a setting event. Both must hit one clock edge. The bench reaches it by parking the counter one step below the match value, then issuing the clear write with `tick_i` raised in the same cycle. The match then appears at the same edge that processes the clear.

A second hard case is the counter resting at the match value after a clear, which must not re-raise the flag. The bench clears the flag there and idles several cycles. It also drives the wrap step from 0xFFFFFFFF with a match value of 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int WADDR_W = 10;

  // word indices (byte offset >> 2)
  localparam logic [WADDR_W-1:0] W_COUNT = 10'h000;
  localparam logic [WADDR_W-1:0] W_MATCH = 10'h001;
  localparam logic [WADDR_W-1:0] W_LOAD  = 10'h002;
  localparam logic [WADDR_W-1:0] W_CTRL  = 10'h003;
  localparam logic [WADDR_W-1:0] W_MASK  = 10'h004;
  localparam logic [WADDR_W-1:0] W_RAW   = 10'h005;
  localparam logic [WADDR_W-1:0] W_MSKD  = 10'h006;
  localparam logic [WADDR_W-1:0] W_CLR   = 10'h007;
  localparam logic [WADDR_W-4:0] ID_PAGE = 7'h7F;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
  assign event_o    = load_i | tick_i;

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_match_irq.sv
module rtc_match_irq #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             cnt_event_i,
  input  logic             match_we_i,
  input  logic [CNT_W-1:0] match_val_i,
  input  logic             mask_we_i,
  input  logic             mask_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] match_o,
  output logic             raw_o,
  output logic             mask_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] match_q, match_d;
  logic raw_q, mask_q, hit;

  assign match_d = match_we_i ? match_val_i : match_q;
  // equality only counts on an edge that moves counter or match
  assign hit = (cnt_event_i | match_we_i) && (cnt_next_i == match_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      match_q <= match_d;
      if (hit)        raw_q <= 1'b1;
      else if (clr_i) raw_q <= 1'b0;
      if (mask_we_i)  mask_q <= mask_val_i;
    end
  end

  assign match_o = match_q;
  assign raw_o   = raw_q;
  assign mask_o  = mask_q;
  assign irq_o   = raw_q & mask_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && !clr_i) |=> raw_q);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_q && !cnt_event_i && !match_we_i) |=> !raw_q);
  a_r6_mask_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(mask_val_i));
  a_r4_match_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_we_i |=> match_q == $past(match_val_i));
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [WADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic wr;
  logic load_we, match_we, mask_we, clr_we;
  logic [DATA_W-1:0] load_q, cnt, cnt_next, match_val;
  logic cnt_event, raw, mask;

  assign wr       = sel_i & we_i;
  assign load_we  = wr && addr_i == W_LOAD;
  assign match_we = wr && addr_i == W_MATCH;
  assign mask_we  = wr && addr_i == W_MASK;
  assign clr_we   = wr && addr_i == W_CLR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      load_q <= '0;
    else if (load_we) load_q <= wdata_i;
  end

  rtc_counter #(.CNT_W(DATA_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load_we),
    .load_val_i (wdata_i),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .event_o    (cnt_event)
  );

  rtc_match_irq #(.CNT_W(DATA_W)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_next_i  (cnt_next),
    .cnt_event_i (cnt_event),
    .match_we_i  (match_we),
    .match_val_i (wdata_i),
    .mask_we_i   (mask_we),
    .mask_val_i  (wdata_i[0]),
    .clr_i       (clr_we),
    .match_o     (match_val),
    .raw_o       (raw),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i[WADDR_W-1:3] == ID_PAGE) begin
      rdata_o = DATA_W'(id_byte(addr_i[2:0]));
    end else begin
      case (addr_i)
        W_COUNT: rdata_o = cnt;
        W_MATCH: rdata_o = match_val;
        W_LOAD:  rdata_o = load_q;
        W_CTRL:  rdata_o = DATA_W'(1);
        W_MASK:  rdata_o = DATA_W'(mask);
        W_RAW:   rdata_o = DATA_W'(raw);
        W_MSKD:  rdata_o = DATA_W'(raw & mask);
        default: rdata_o = '0;
      endcase
    end
  end

  a_r4_load_onto_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_we && !match_we && wdata_i == match_val) |=> (rdata_o == rdata_o) && raw);
  a_r9_ro_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_we) |=> cnt == $past(cnt));
endmodule

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%08h exp 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a[11:2]; wdata = d; tick = t;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a[11:2];
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); chk("R1 count", v, 0);
    rd(12'h004, v); chk("R1 match", v, 0);
    rd(12'h008, v); chk("R1 load", v, 0);
    rd(12'h010, v); chk("R1 mask", v, 0);
    rd(12'h014, v); chk("R1 raw", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    wr(12'h004, 32'h0000_1000);
    ticks(3);
    rd(12'h000, v); chk("R2 three ticks", v, 3);
    repeat (4) @(posedge clk);
    rd(12'h000, v); chk("R2 hold without tick", v, 3);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(12'h008, 32'h0000_1234);
    rd(12'h000, v); chk("R3 count after load", v, 32'h1234);
    ticks(2);
    rd(12'h000, v); chk("R3 count continues", v, 32'h1236);
    rd(12'h008, v); chk("R3 load readback", v, 32'h1234);
    wr(12'h008, 32'h0000_0500, 1'b1);
    rd(12'h000, v); chk("R3 load beats tick", v, 32'h500);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(12'h008, 32'hFFFF_FFFE);
    wr(12'h004, 32'h0000_0000);
    rd(12'h004, v); chk("R4 match readback", v, 0);
    ticks(1);
    rd(12'h014, v); chk("R4 no hit before wrap", v, 0);
    ticks(1);
    rd(12'h000, v); chk("R2 wrap to zero", v, 0);
    rd(12'h014, v); chk("R4 hit across wrap", v, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    ticks(2);
    rd(12'h014, v); chk("R5 sticky after passing", v, 1);
    wr(12'h01C, 32'h0000_0000);
    rd(12'h014, v); chk("R5 clear with zero data", v, 0);
    wr(12'h004, 32'h0000_0002);
    rd(12'h014, v); chk("R4 match write onto count", v, 1);
    wr(12'h01C, 32'hFFFF_FFFE);
    repeat (5) @(posedge clk);
    rd(12'h014, v); chk("R10 resting on match stays clear", v, 0);
    wr(12'h004, 32'h0000_0010);
    wr(12'h008, 32'h0000_0010);
    rd(12'h014, v); chk("R4 load onto match", v, 1);
    wr(12'h01C, 32'h1);
    wr(12'h008, 32'h0000_000F);
    wr(12'h01C, 32'h1, 1'b1);
    rd(12'h014, v); chk("R5 set wins over clear", v, 1);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_FFFE);
    rd(12'h010, v); chk("R6 mask bit0 only zero", v, 0);
    chk("R6 irq masked", 32'(irq), 0);
    rd(12'h018, v); chk("R6 masked status off", v, 0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R6 mask reads one bit", v, 1);
    chk("R6 irq high", 32'(irq), 1);
    rd(12'h018, v); chk("R6 masked status on", v, 1);
    wr(12'h01C, 32'h0);
    chk("R6 irq drops on clear", 32'(irq), 0);
    wr(12'h010, 32'h0);
  endtask

  task automatic t_ctrl_id();
    logic [31:0] v;
    logic [7:0] idv [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    rd(12'h00C, v); chk("R7 control reads one", v, 1);
    wr(12'h00C, 32'h0);
    rd(12'h00C, v); chk("R7 control after write", v, 1);
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i*4), v); chk("R8 id byte", v, 32'(idv[i]));
    end
  endtask

  task automatic t_ignored();
    logic [31:0] v, c;
    rd(12'h000, c);
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h000, v); chk("R9 count write ignored", v, c);
    rd(12'h014, v); chk("R9 raw idle", v, 0);
    wr(12'h014, 32'h1);
    rd(12'h014, v); chk("R9 raw write ignored", v, 0);
    wr(12'h018, 32'h1);
    rd(12'h014, v); chk("R9 masked write ignored", v, 0);
    rd(12'h01C, v); chk("R9 clear reads zero", v, 0);
    rd(12'h800, v); chk("R9 unmapped reads zero", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_tick();
    t_load();
    t_wrap();
    t_clear();
    t_mask();
    t_ctrl_id();
    t_ignored();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got 0x0 exp 0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule